// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block is the timing core of an SPI controller. It turns one packed word of timing attributes into clock-cycle counts. It then plays one frame out on a fixed schedule:

1. A lead gap between chip-select assertion and the first serial clock edge.
2. The serial clock for a programmed number of bits.
3. A trail gap before chip-select is released.
4. An idle gap in which the block stays busy, so that a new frame cannot start yet.

The frame engine beside it uses two single-cycle strobes. One marks where outgoing data should change and one marks where incoming data should be captured.

The serial clock period is a small prescaler times a scaler taken from a table. Each of the three gaps is an odd prescaler times a power of two. The attribute word, clock polarity, clock phase and bit count are captured when a frame is accepted. Changes to them during the frame have no effect.

Top module: `spi_timing_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `busy_o`, `cs_o`, `launch_o`, `sample_o` and all three done pulses are 0, and `sck_o` equals `cpol_i`.
- R2: The serial clock period in cycles, `div`, is the baud prescaler times the baud scaler, and each bit lasts `div` cycles with `sck_o` at the active level for exactly `div/2` of them. The baud prescaler comes from `cfg_i[17:16]` with codes 0..3 giving 2, 3, 5 and 7. The baud scaler comes from `cfg_i[3:0]`: code c below 4 gives 2(c+1), and any other code gives 2^c.
- R3: Each gap length is (2p+1)·2^(s+1) cycles, where p is its 2-bit prescaler and s its 4-bit scaler. The lead gap takes p from `cfg_i[23:22]` and s from `cfg_i[15:12]`. The trail gap takes p from `cfg_i[21:20]` and s from `cfg_i[11:8]`. The idle gap takes p from `cfg_i[19:18]` and s from `cfg_i[7:4]`.
- R4: The frame sequence is fixed. `start_i` is accepted on a clock edge while idle. From the next cycle `cs_o` is high for lead + N·div + trail cycles. `busy_o` is high for that span plus the idle gap, then the block returns to idle.
- R5: A frame carries N = `frame_len_i`+1 bits and gives exactly N `sample_o` pulses.
- R6: `sck_o` rests at `cpol_i` when idle and at the captured polarity whenever chip-select is low inside a frame. The active level is its inverse.
- R7: With clock phase 1, each bit starts at the active level. `launch_o` pulses in the first cycle of every bit and `sample_o` in cycle `div/2` of the bit. With clock phase 0, each bit starts at the idle level and `sample_o` pulses at the first active cycle. `launch_o` pulses in the first cycle of every bit except the first one. The two strobes never coincide.
- R8: `lead_done_o`, `trail_done_o` and `gap_done_o` each pulse exactly once per frame, in the last cycle of their gap.
- R9: `start_i` while busy is ignored. Attribute, polarity, phase and length inputs are captured only with an accepted start, and changes to them during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request, taken only when idle |
| cfg_i | input | 24 | Packed baud and gap prescaler/scaler fields |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| frame_len_i | input | BITS_W | Bits per frame minus one |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip-select active (high = asserted) |
| launch_o | output | 1 | Strobe: shift next outgoing bit |
| sample_o | output | 1 | Strobe: capture incoming bit |
| lead_done_o | output | 1 | Last cycle of the lead gap |
| trail_done_o | output | 1 | Last cycle of the trail gap |
| gap_done_o | output | 1 | Last cycle of the idle gap |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench uses the default parameters: a 20-bit cycle counter and a 4-bit length field. With these, 16-bit frames and the top baud scaler code can run, and one frame at a 65536-cycle bit period fits the run. Gap scalers are driven up to code 11. Random frames use small scaler codes so that many polarity, phase, length and prescaler combinations fit in the cycle budget. Some frames scramble every input and re-pulse start in mid-frame.

// File: rtl/spi_timing_pkg.sv
package spi_timing_pkg;
  localparam int CFG_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP
  } tg_state_e;

  function automatic logic [2:0] baud_pre(input logic [1:0] c);
    case (c)
      2'd0: baud_pre = 3'd2;
      2'd1: baud_pre = 3'd3;
      2'd2: baud_pre = 3'd5;
      default: baud_pre = 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] baud_scl(input logic [3:0] c);
    if (c < 4'd4) baud_scl = 16'({12'd0, c} + 16'd1) << 1;
    else          baud_scl = 16'd1 << c;
  endfunction

  function automatic logic [2:0] dly_pre(input logic [1:0] c);
    dly_pre = {c, 1'b1};
  endfunction

  function automatic logic [16:0] dly_scl(input logic [3:0] n);
    dly_scl = 17'd1 << ({1'b0, n} + 5'd1);
  endfunction
endpackage

// File: rtl/spi_timing_decode.sv
module spi_timing_decode
  import spi_timing_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CFG_W-1:0]            cfg_i,
  output logic [CNT_W-1:0]            sck_div_o,
  output logic [CNT_W-1:0]            sck_half_o,
  output logic [2:0][CNT_W-1:0]       dly_len_o
);
  // 0: lead, 1: trail, 2: idle gap
  for (genvar g = 0; g < 3; g++) begin : g_dly
    localparam int PL = 22 - 2*g;
    localparam int SL = 12 - 4*g;
    assign dly_len_o[g] = CNT_W'(dly_pre(cfg_i[PL +: 2])) * CNT_W'(dly_scl(cfg_i[SL +: 4]));
  end

  assign sck_div_o  = CNT_W'(baud_pre(cfg_i[17:16])) * CNT_W'(baud_scl(cfg_i[3:0]));
  assign sck_half_o = sck_div_o >> 1;
endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= len_i - CNT_W'(1);
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int CNT_W  = 20,
  parameter int BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpha_i,
  input  logic [CNT_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic [BITS_W-1:0] last_bit_i,
  output logic              active_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  pc_q;
  logic [BITS_W-1:0] bc_q;
  logic [CNT_W-1:0]  lo;
  logic              bit_end;

  assign lo      = div_i - half_i;
  assign bit_end = (pc_q == div_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      bc_q <= '0;
    end else if (!en_i) begin
      pc_q <= '0;
      bc_q <= '0;
    end else if (bit_end) begin
      pc_q <= '0;
      bc_q <= bc_q + BITS_W'(1);
    end else begin
      pc_q <= pc_q + CNT_W'(1);
    end
  end

  always_comb begin
    active_o = en_i && (cpha_i ? (pc_q < half_i) : (pc_q >= lo));
    launch_o = en_i && (pc_q == '0) && (cpha_i || bc_q != '0);
    sample_o = en_i && (pc_q == (cpha_i ? half_i : lo));
    done_o   = en_i && bit_end && (bc_q == last_bit_i);
  end

  assert_pc_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (pc_q < div_i));
  assert_edge_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));
endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
  import spi_timing_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [BITS_W-1:0] frame_len_i,
  output logic              sck_o,
  output logic              cs_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              lead_done_o,
  output logic              trail_done_o,
  output logic              gap_done_o,
  output logic              busy_o
);
  tg_state_e          state_q, state_d;
  logic [CFG_W-1:0]   cfg_q, cfg_sel;
  logic               cpol_q, cpha_q;
  logic [BITS_W-1:0]  len_q;
  logic               idle, accept;
  logic [CNT_W-1:0]   sck_div, sck_half;
  logic [2:0][CNT_W-1:0] dly_len;
  logic               tmr_load, tmr_run, tmr_zero;
  logic [CNT_W-1:0]   tmr_len;
  logic               sck_act, sck_done;

  assign idle    = (state_q == ST_IDLE);
  assign accept  = idle && start_i;
  // live attributes feed the lead load on the accepting edge
  assign cfg_sel = idle ? cfg_i : cfg_q;

  spi_timing_decode #(.CNT_W(CNT_W)) u_decode (
    .cfg_i      (cfg_sel),
    .sck_div_o  (sck_div),
    .sck_half_o (sck_half),
    .dly_len_o  (dly_len)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = dly_len[0];
    if (accept) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_SHIFT && sck_done) begin
      tmr_load = 1'b1;
      tmr_len  = dly_len[1];
    end else if (state_q == ST_TRAIL && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_len  = dly_len[2];
    end
  end

  assign tmr_run = (state_q == ST_LEAD) || (state_q == ST_TRAIL) || (state_q == ST_GAP);

  spi_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .run_i  (tmr_run),
    .zero_o (tmr_zero)
  );

  spi_sck_gen #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state_q == ST_SHIFT),
    .cpha_i     (cpha_q),
    .div_i      (sck_div),
    .half_i     (sck_half),
    .last_bit_i (len_q),
    .active_o   (sck_act),
    .launch_o   (launch_o),
    .sample_o   (sample_o),
    .done_o     (sck_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_LEAD;
      ST_LEAD:  if (tmr_zero) state_d = ST_SHIFT;
      ST_SHIFT: if (sck_done) state_d = ST_TRAIL;
      ST_TRAIL: if (tmr_zero) state_d = ST_GAP;
      ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cfg_q  <= cfg_i;
        cpol_q <= cpol_i;
        cpha_q <= cpha_i;
        len_q  <= frame_len_i;
      end
    end
  end

  assign busy_o       = !idle;
  assign cs_o         = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
  assign lead_done_o  = (state_q == ST_LEAD)  && tmr_zero;
  assign trail_done_o = (state_q == ST_TRAIL) && tmr_zero;
  assign gap_done_o   = (state_q == ST_GAP)   && tmr_zero;
  assign sck_o        = idle ? cpol_i : (cpol_q ^ sck_act);

  assert_cs_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o);
  assert_cs_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> $past(trail_done_o));
  assert_cs_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

// File: tb/spi_timing_gen_bench.sv
module spi_timing_gen_bench;
  localparam int BITS_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [23:0]       cfg_i = '0;
  logic              cpol_i = 1'b0;
  logic              cpha_i = 1'b0;
  logic [BITS_W-1:0] frame_len_i = '0;
  logic sck_o, cs_o, launch_o, sample_o, lead_done_o, trail_done_o, gap_done_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_timing_gen u_spi_timing_gen (
    .clk_i, .rst_ni, .start_i, .cfg_i, .cpol_i, .cpha_i, .frame_len_i,
    .sck_o, .cs_o, .launch_o, .sample_o, .lead_done_o, .trail_done_o,
    .gap_done_o, .busy_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bpre(input int c);
    return (c == 0) ? 2 : (c == 1) ? 3 : (c == 2) ? 5 : 7;
  endfunction
  function automatic int bscl(input int c);
    return (c < 4) ? 2 * (c + 1) : (1 << c);
  endfunction
  function automatic int gap_len(input int p, input int s);
    return (2 * p + 1) * (1 << (s + 1));
  endfunction
  function automatic logic [23:0] mk_cfg(input int lp, input int ls, input int tp, input int ts,
                                         input int gp, input int gs, input int bp, input int bs);
    logic [23:0] c;
    c = '0;
    c[23:22] = 2'(lp); c[15:12] = 4'(ls);
    c[21:20] = 2'(tp); c[11:8]  = 4'(ts);
    c[19:18] = 2'(gp); c[7:4]   = 4'(gs);
    c[17:16] = 2'(bp); c[3:0]   = 4'(bs);
    return c;
  endfunction

  task automatic run_frame(input logic [23:0] cfg, input bit pol, input bit pha,
                           input int len, input bit disturb);
    int L, A, G, dv, hf, N, t;
    int busy_n = 0, cs_n = 0, act_n = 0, f_act = -1, l_act = -1, idle_bad = 0;
    int samp_n = 0, f_samp = -1, lau_n = 0, f_lau = -1;
    int ld_n = 0, ld_t = -1, tr_n = 0, tr_t = -1, gp_n = 0, gp_t = -1;
    L  = gap_len(int'(cfg[23:22]), int'(cfg[15:12]));
    A  = gap_len(int'(cfg[21:20]), int'(cfg[11:8]));
    G  = gap_len(int'(cfg[19:18]), int'(cfg[7:4]));
    dv = bpre(int'(cfg[17:16])) * bscl(int'(cfg[3:0]));
    hf = dv / 2;
    N  = len + 1;
    @(negedge clk_i);
    cfg_i = cfg; cpol_i = pol; cpha_i = pha; frame_len_i = BITS_W'(len); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (busy_o && t < 200000) begin
      busy_n++;
      if (cs_o) cs_n++;
      if (sck_o != pol) begin
        act_n++;
        if (f_act < 0) f_act = t;
        l_act = t;
        if (!cs_o) idle_bad++;
      end
      if (sample_o) begin samp_n++; if (f_samp < 0) f_samp = t; end
      if (launch_o) begin lau_n++;  if (f_lau < 0)  f_lau = t;  end
      if (lead_done_o)  begin ld_n++; ld_t = t; end
      if (trail_done_o) begin tr_n++; tr_t = t; end
      if (gap_done_o)   begin gp_n++; gp_t = t; end
      if (disturb && t == 1) begin
        start_i = 1'b1; cfg_i = ~cfg; cpol_i = ~pol; cpha_i = ~pha; frame_len_i = ~frame_len_i;
      end
      if (disturb && t == 2) start_i = 1'b0;
      @(negedge clk_i);
      t++;
    end
    start_i = 1'b0;
    // R9: disturbed frames must still match the captured attributes
    chk("R4", "busy cycles", busy_n, L + N * dv + A + G);
    chk("R4", "chip-select cycles", cs_n, L + N * dv + A);
    chk("R2", "active-level cycles", act_n, N * hf);
    chk("R7", "first active cycle", f_act, L + (pha ? 0 : dv - hf));
    chk("R7", "last active cycle", l_act, L + (N - 1) * dv + (pha ? hf - 1 : dv - 1));
    chk("R6", "active level with chip-select low", idle_bad, 0);
    chk("R5", "sample pulses", samp_n, N);
    chk("R7", "first sample cycle", f_samp, L + (pha ? hf : dv - hf));
    chk("R7", "launch pulses", lau_n, pha ? N : N - 1);
    chk("R7", "first launch cycle", f_lau, pha ? L : ((N > 1) ? L + dv : -1));
    chk("R8", "lead done count", ld_n, 1);
    chk("R8", "trail done count", tr_n, 1);
    chk("R8", "gap done count", gp_n, 1);
    chk("R3", "lead done cycle", ld_t, L - 1);
    chk("R3", "trail done cycle", tr_t, L + N * dv + A - 1);
    chk("R3", "gap done cycle", gp_t, L + N * dv + A + G - 1);
    if (disturb) chk("R9", "busy cycles after mid-frame start", busy_n, L + N * dv + A + G);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    cpol_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", "sck in reset, polarity 1", int'(sck_o), 1);
    chk("R1", "busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk("R1", "sck idle, polarity 0", int'(sck_o), 0);
    chk("R1", "chip-select idle", int'(cs_o), 0);
    chk("R1", "strobes idle", int'({launch_o, sample_o, lead_done_o, trail_done_o, gap_done_o}), 0);
    chk("R1", "busy idle", int'(busy_o), 0);

    run_frame(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0), 1'b0, 1'b0, 0, 1'b0);
    run_frame(mk_cfg(1, 2, 2, 1, 3, 0, 3, 3), 1'b1, 1'b1, 15, 1'b1);
    run_frame(mk_cfg(0, 1, 1, 0, 0, 2, 0, 15), 1'b0, 1'b1, 0, 1'b0);
    run_frame(mk_cfg(3, 11, 0, 0, 0, 0, 1, 1), 1'b1, 1'b0, 3, 1'b0);
    run_frame(mk_cfg(2, 0, 3, 3, 1, 1, 0, 8), 1'b0, 1'b0, 1, 1'b1);
    run_frame(mk_cfg(0, 0, 0, 0, 0, 0, 2, 7), 1'b1, 1'b1, 2, 1'b0);

    for (int i = 0; i < 16; i++) begin
      run_frame(mk_cfg($urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 3),
                       $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 4),
                       $urandom_range(0, 3), $urandom_range(0, 4)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 15), 1'($urandom_range(0, 1)));
    end

    @(negedge clk_i);
    cpol_i = 1'b1;
    @(negedge clk_i);
    chk("R6", "idle level follows polarity input", int'(sck_o), 1);
    chk("R1", "idle after frames", int'(busy_o), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule